// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects 32 level-sensitive interrupt request lines and turns them into two processor interrupt lines, a fast one (`fiq_o`) and a normal one (`irq_o`). Each source is steered to one of the two lines by a per-source route bit. Software can enable or disable each source. It can also raise any source by writing a software-request register. A raw view of all requests, whether enabled or not, stays readable at all times.

Sixteen vector slots give the normal line a priority scheme. Each slot binds a source channel to a service-routine address, and slot 0 outranks slot 15. A read of the vector register returns the address of the best matching slot, or a programmable default address when no enabled slot matches. A small acknowledge state machine has two states, `VS_IDLE` and `VS_HELD`. A vector read in `VS_IDLE` latches the returned address and moves to `VS_HELD`. Further vector reads in `VS_HELD` return the latched value. A write to the vector register is the end-of-interrupt and returns the machine to `VS_IDLE`. No other transitions exist. A protection bit can lock out accesses that do not carry the privilege flag.

Access is through a synchronous register bus with single-cycle read and write strobes. Read data appears on the cycle after the read strobe. Both interrupt outputs are registered, so they follow a status change one cycle later.

Top module: `vic_top`

## Requirements
- R1: After reset, every enable, route, software-request, slot-control and protection bit is zero, and both interrupt outputs are low.
- R2: A read at 0x008 returns the OR of the request lines and the software requests for every source, whatever its enable.
- R3: A write at 0x018 sets the software requests at its one bits, and a write at 0x01C clears them at its one bits. Zero bits change nothing.
- R4: A write at 0x010 sets the enables at its one bits, and a write at 0x014 clears them at its one bits. Zero bits change nothing. A read at 0x010 returns the enables.
- R5: The route register at 0x00C selects the line for each source: a one bit picks the fast line and a zero bit picks the normal line. The fast status (read at 0x004) is raw AND enable AND route. The normal status (read at 0x000) is raw AND enable AND NOT route. Each output is the OR of its status, one cycle after the status changes.
- R6: Each slot i has an address word at 0x100+4i and a control word at 0x200+4i. In the control word, bits 4:0 hold the channel and bit 5 is the enable. A slot matches only when it is enabled and its channel has normal status set. A vector read (0x030) returns the address of the lowest-numbered matching slot.
- R7: When no slot matches, a vector read returns the default address held at 0x034.
- R8: A vector read in `VS_IDLE` latches its value. Later vector reads return that value until a write at 0x030 releases it, and the normal output keeps following the live status meanwhile.
- R9: While the protection bit (0x020, bit 0) is set, writes without the privilege flag are ignored, and reads without it return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 32 | Level-sensitive request lines |
| bus_addr | input | 12 | Byte register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_priv | input | 1 | Privileged access flag |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| fiq_o | output | 1 | Fast interrupt line |
| irq_o | output | 1 | Normal interrupt line |

## Verification
The assertions assume that read and write strobes are never raised in the same cycle. They also assume addresses are word aligned and that `src_req` changes only between clock edges. The stimulus drives every bus access from a task that raises exactly one strobe on the falling edge, holds it for one cycle, and then drops it. Request lines are changed only on falling edges while the bus is idle. The end-of-interrupt write is always issued before a new vector priority is expected.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int NSRC  = 32;
    localparam int NSLOT = 16;
    localparam int CH_W  = $clog2(NSRC);
    localparam int AW    = 12;
    localparam int DW    = 32;

    localparam logic [AW-1:0] OFF_IRQST = 12'h000;
    localparam logic [AW-1:0] OFF_FIQST = 12'h004;
    localparam logic [AW-1:0] OFF_RAW   = 12'h008;
    localparam logic [AW-1:0] OFF_ROUTE = 12'h00C;
    localparam logic [AW-1:0] OFF_ENSET = 12'h010;
    localparam logic [AW-1:0] OFF_ENCLR = 12'h014;
    localparam logic [AW-1:0] OFF_SWSET = 12'h018;
    localparam logic [AW-1:0] OFF_SWCLR = 12'h01C;
    localparam logic [AW-1:0] OFF_PROT  = 12'h020;
    localparam logic [AW-1:0] OFF_VEC   = 12'h030;
    localparam logic [AW-1:0] OFF_DEFV  = 12'h034;
    localparam logic [3:0]    PG_SADDR  = 4'h1;
    localparam logic [3:0]    PG_SCTL   = 4'h2;

    typedef struct packed {
        logic            en;
        logic [CH_W-1:0] chan;
    } slot_ctl_t;

    typedef enum logic {
        VS_IDLE,
        VS_HELD
    } ack_state_e;
endpackage

// File: rtl/vic_regfile.sv
module vic_regfile
    import vic_pkg::*;
#(
    parameter int NUM_SRC  = NSRC,
    parameter int NUM_SLOT = NSLOT,
    parameter int ADDR_W   = AW,
    parameter int DATA_W   = DW
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_wr,
    input  logic                            bus_priv,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [DATA_W-1:0]               bus_wdata,
    output logic                            wr_ok,
    output logic                            prot_q,
    output logic [NUM_SRC-1:0]              route_q,
    output logic [NUM_SRC-1:0]              en_q,
    output logic [NUM_SRC-1:0]              soft_q,
    output logic [DATA_W-1:0]               defv_q,
    output logic [NUM_SLOT-1:0][DATA_W-1:0] slot_addr,
    output slot_ctl_t [NUM_SLOT-1:0]        slot_ctl
);
    logic [5:0]         widx;
    logic               slot_pg_ok;
    logic [NUM_SRC-1:0] wd;

    assign wr_ok      = bus_wr && (!prot_q || bus_priv);
    assign widx       = bus_addr[7:2];
    assign wd         = bus_wdata[NUM_SRC-1:0];
    assign slot_pg_ok = wr_ok && (bus_addr[1:0] == 2'b00) && (int'(widx) < NUM_SLOT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q  <= 1'b0;
            route_q <= '0;
            en_q    <= '0;
            soft_q  <= '0;
            defv_q  <= '0;
        end else if (wr_ok) begin
            unique case (bus_addr)
                OFF_PROT:  prot_q  <= bus_wdata[0];
                OFF_ROUTE: route_q <= wd;
                OFF_ENSET: en_q    <= en_q | wd;
                OFF_ENCLR: en_q    <= en_q & ~wd;
                OFF_SWSET: soft_q  <= soft_q | wd;
                OFF_SWCLR: soft_q  <= soft_q & ~wd;
                OFF_DEFV:  defv_q  <= bus_wdata;
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < NUM_SLOT; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_addr[i] <= '0;
                slot_ctl[i]  <= '0;
            end else if (slot_pg_ok && widx == 6'(i)) begin
                if (bus_addr[ADDR_W-1:8] == PG_SADDR)
                    slot_addr[i] <= bus_wdata;
                if (bus_addr[ADDR_W-1:8] == PG_SCTL)
                    slot_ctl[i] <= slot_ctl_t'(bus_wdata[CH_W:0]);
            end
        end
    end

    assert_swset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && bus_addr == OFF_SWSET) |=> ((soft_q & $past(wd)) == $past(wd)));
    assert_swclr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && bus_addr == OFF_SWCLR) |=> ((soft_q & $past(wd)) == '0));
    assert_enclr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && bus_addr == OFF_ENCLR) |=> ((en_q & $past(wd)) == '0));
    assert_lockout_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_q && bus_wr && !bus_priv) |=> ($stable(en_q) && $stable(soft_q) && $stable(prot_q)));
endmodule

// File: rtl/vic_slot_pick.sv
module vic_slot_pick
    import vic_pkg::*;
#(
    parameter int NUM_SRC  = NSRC,
    parameter int NUM_SLOT = NSLOT,
    localparam int SLOT_IW = $clog2(NUM_SLOT)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       irq_st,
    input  slot_ctl_t [NUM_SLOT-1:0] slot_ctl,
    output logic                     hit,
    output logic [SLOT_IW-1:0]       idx
);
    logic [NUM_SLOT-1:0] ok;

    for (genvar i = 0; i < NUM_SLOT; i++) begin : g_ok
        assign ok[i] = slot_ctl[i].en && irq_st[slot_ctl[i].chan];
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NUM_SLOT - 1; i >= 0; i--) begin
            if (ok[i]) begin
                hit = 1'b1;
                idx = SLOT_IW'(i);
            end
        end
    end

    assert_match_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (slot_ctl[idx].en && irq_st[slot_ctl[idx].chan]));
    assert_no_better_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((ok & ~({NUM_SLOT{1'b1}} << idx)) == '0));
endmodule

// File: rtl/vic_ack_fsm.sv
module vic_ack_fsm
    import vic_pkg::*;
#(
    parameter int DATA_W = DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_vec,
    input  logic              wr_vec,
    input  logic [DATA_W-1:0] live_addr,
    output logic              held,
    output logic [DATA_W-1:0] held_addr
);
    ack_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= VS_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            VS_IDLE: if (rd_vec) nxt = VS_HELD;
            VS_HELD: if (wr_vec) nxt = VS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                        held_addr <= '0;
        else if (state == VS_IDLE && rd_vec) held_addr <= live_addr;
    end

    always_comb held = (state == VS_HELD);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == VS_HELD && !wr_vec) |=> (state == VS_HELD && $stable(held_addr)));
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == VS_HELD && wr_vec) |=> (state == VS_IDLE));
endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
#(
    parameter int NUM_SRC  = NSRC,
    parameter int NUM_SLOT = NSLOT,
    parameter int ADDR_W   = AW,
    parameter int DATA_W   = DW,
    localparam int SLOT_IW = $clog2(NUM_SLOT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic               bus_priv,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               fiq_o,
    output logic               irq_o
);
    logic                            wr_ok, rd_ok, prot_q;
    logic [NUM_SRC-1:0]              route_q, en_q, soft_q;
    logic [NUM_SRC-1:0]              raw, irq_st, fiq_st;
    logic [DATA_W-1:0]               defv_q, live_addr, held_addr, vec_val, rd_mux;
    logic [NUM_SLOT-1:0][DATA_W-1:0] slot_addr;
    slot_ctl_t [NUM_SLOT-1:0]        slot_ctl;
    logic                            hit, held, rd_vec, wr_vec;
    logic [SLOT_IW-1:0]              idx;
    logic [5:0]                      ridx;

    vic_regfile #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_priv(bus_priv),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .wr_ok(wr_ok), .prot_q(prot_q),
        .route_q(route_q), .en_q(en_q), .soft_q(soft_q), .defv_q(defv_q),
        .slot_addr(slot_addr), .slot_ctl(slot_ctl)
    );

    assign raw    = src_req | soft_q;
    assign fiq_st = raw & en_q & route_q;
    assign irq_st = raw & en_q & ~route_q;

    vic_slot_pick #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT)) u_pick (
        .clk(clk), .rst_n(rst_n), .irq_st(irq_st), .slot_ctl(slot_ctl),
        .hit(hit), .idx(idx)
    );

    assign live_addr = hit ? slot_addr[idx] : defv_q;
    assign rd_ok     = bus_rd && (!prot_q || bus_priv);
    assign rd_vec    = rd_ok && bus_addr == OFF_VEC;
    assign wr_vec    = wr_ok && bus_addr == OFF_VEC;

    vic_ack_fsm #(.DATA_W(DATA_W)) u_ack (
        .clk(clk), .rst_n(rst_n), .rd_vec(rd_vec), .wr_vec(wr_vec),
        .live_addr(live_addr), .held(held), .held_addr(held_addr)
    );

    assign vec_val = held ? held_addr : live_addr;
    assign ridx    = bus_addr[7:2];

    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            OFF_IRQST: rd_mux = DATA_W'(irq_st);
            OFF_FIQST: rd_mux = DATA_W'(fiq_st);
            OFF_RAW:   rd_mux = DATA_W'(raw);
            OFF_ROUTE: rd_mux = DATA_W'(route_q);
            OFF_ENSET: rd_mux = DATA_W'(en_q);
            OFF_PROT:  rd_mux = DATA_W'(prot_q);
            OFF_VEC:   rd_mux = vec_val;
            OFF_DEFV:  rd_mux = defv_q;
            default: begin
                if (bus_addr[1:0] == 2'b00 && int'(ridx) < NUM_SLOT) begin
                    if (bus_addr[ADDR_W-1:8] == PG_SADDR)
                        rd_mux = slot_addr[ridx[SLOT_IW-1:0]];
                    else if (bus_addr[ADDR_W-1:8] == PG_SCTL)
                        rd_mux = DATA_W'(slot_ctl[ridx[SLOT_IW-1:0]]);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            fiq_o     <= 1'b0;
            irq_o     <= 1'b0;
        end else begin
            fiq_o <= |fiq_st;
            irq_o <= |irq_st;
            if (bus_rd) bus_rdata <= rd_ok ? rd_mux : '0;
        end
    end

    assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |=> (!irq_o && !fiq_o));
    assert_one_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((route_q == '0) && (soft_q == '0) && (src_req == '0)) |=> !fiq_o);
    assert_default_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vec && !held && !hit) |=> (bus_rdata == $past(defv_q)));
    assert_unpriv_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && prot_q && !bus_priv) |=> (bus_rdata == '0));
endmodule

// File: tb/vic_top_tb.sv
module vic_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_req = '0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_priv = 1'b1;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fiq_o, irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic rd_d = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    vic_top u_dut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_priv(bus_priv), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .fiq_o(fiq_o), .irq_o(irq_o)
    );

    always @(posedge clk) rd_d <= bus_rd;

    // monitor: compare read data against the scoreboard queue
    always @(negedge clk) begin
        if (rd_d && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
            end
        end
    end

    task automatic bw(input logic [11:0] a, input logic [31:0] d, input logic p = 1'b1);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_priv = p; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_priv = 1'b1;
    endtask

    task automatic br(input logic [11:0] a, input logic [31:0] e, input string t, input logic p = 1'b1);
        @(negedge clk);
        bus_addr = a; bus_priv = p; bus_rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0; bus_priv = 1'b1;
    endtask

    task automatic pin(input logic f, input logic i, input logic ef, input logic ei, input string t);
        checks++;
        if (f !== ef || i !== ei) begin
            errors++;
            $display("FAIL %s actual fiq=%b irq=%b expected fiq=%b irq=%b", t, f, i, ef, ei);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        pin(fiq_o, irq_o, 1'b0, 1'b0, "R1 outputs after reset");
        br(12'h010, 32'h0, "R1 enables after reset");
        br(12'h00C, 32'h0, "R1 route after reset");
        br(12'h020, 32'h0, "R1 protection after reset");
        br(12'h200, 32'h0, "R1 slot control after reset");

        // R2: raw shows disabled request
        src_req = 32'h10;
        br(12'h008, 32'h10, "R2 raw with source disabled");
        pin(fiq_o, irq_o, 1'b0, 1'b0, "R2 disabled source stays silent");

        // R3: software set/clear
        bw(12'h018, 32'h3);
        br(12'h008, 32'h13, "R3 soft set");
        bw(12'h018, 32'h0);
        br(12'h008, 32'h13, "R3 soft set zero no effect");
        bw(12'h01C, 32'h1);
        br(12'h008, 32'h12, "R3 soft clear");
        bw(12'h01C, 32'h0);
        br(12'h008, 32'h12, "R3 soft clear zero no effect");

        // R4: enable set/clear
        bw(12'h010, 32'h12);
        br(12'h010, 32'h12, "R4 enable set");
        bw(12'h010, 32'h0);
        br(12'h010, 32'h12, "R4 enable set zero no effect");
        bw(12'h014, 32'h2);
        br(12'h010, 32'h10, "R4 enable clear");
        bw(12'h014, 32'h0);
        br(12'h010, 32'h10, "R4 enable clear zero no effect");

        // R5: steering and latency
        br(12'h000, 32'h10, "R5 normal status");
        pin(fiq_o, irq_o, 1'b0, 1'b1, "R5 normal line");
        bw(12'h00C, 32'h10);
        pin(fiq_o, irq_o, 1'b0, 1'b1, "R5 output one cycle late");
        @(negedge clk);
        pin(fiq_o, irq_o, 1'b1, 1'b0, "R5 fast line after route");
        br(12'h004, 32'h10, "R5 fast status");
        br(12'h000, 32'h0, "R5 normal status empty");
        bw(12'h00C, 32'h0);
        bw(12'h01C, 32'hFFFF_FFFF);
        bw(12'h014, 32'hFFFF_FFFF);
        src_req = 32'h0;

        // R6: slot priority
        bw(12'h034, 32'hDEAD_0000);
        bw(12'h100 + 12'd4, 32'hA000_0100);
        bw(12'h200 + 12'd4, 32'h0000_0003);        // slot 1 disabled, chan 3
        bw(12'h100 + 12'd8, 32'hA000_0200);
        bw(12'h200 + 12'd8, 32'h0000_0027);        // slot 2 enabled, chan 7
        bw(12'h100 + 12'd20, 32'hA000_0500);
        bw(12'h200 + 12'd20, 32'h0000_0023);       // slot 5 enabled, chan 3
        br(12'h208, 32'h27, "R6 slot control readback");
        src_req = 32'h88;
        bw(12'h010, 32'h88);
        br(12'h030, 32'hA000_0200, "R6 lowest enabled slot wins");
        bw(12'h030, 32'h0);
        src_req = 32'h08;
        br(12'h030, 32'hA000_0500, "R6 next slot after source drops");
        bw(12'h030, 32'h0);
        bw(12'h00C, 32'h08);
        br(12'h030, 32'hDEAD_0000, "R6 fast-routed source matches no slot");
        bw(12'h030, 32'h0);
        bw(12'h00C, 32'h0);

        // R7: active source without a slot
        bw(12'h014, 32'h88);
        src_req = 32'h200;
        bw(12'h010, 32'h200);
        br(12'h030, 32'hDEAD_0000, "R7 default address");
        bw(12'h030, 32'h0);

        // R8: latch and release
        src_req = 32'h208;
        bw(12'h010, 32'h08);
        br(12'h030, 32'hA000_0500, "R8 first vector read");
        bw(12'h100 + 12'd20, 32'hB000_0500);
        src_req = 32'h288;
        bw(12'h010, 32'h80);
        br(12'h030, 32'hA000_0500, "R8 latched value held");
        pin(fiq_o, irq_o, 1'b0, 1'b1, "R8 normal line follows status");
        bw(12'h030, 32'h0);
        br(12'h030, 32'hA000_0200, "R8 released after end of interrupt");
        bw(12'h030, 32'h0);

        // R9: protection
        bw(12'h020, 32'h1);
        br(12'h010, 32'h0, "R9 unprivileged read returns zero", 1'b0);
        bw(12'h014, 32'hFFFF_FFFF, 1'b0);
        br(12'h010, 32'h288, "R9 unprivileged write ignored");
        bw(12'h020, 32'h0, 1'b0);
        br(12'h020, 32'h1, "R9 protection survives unprivileged write");
        bw(12'h020, 32'h0);
        br(12'h010, 32'h288, "R9 unprivileged read after unlock", 1'b0);

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard actual=%0d expected=0 pending", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule